// File: doc/BRIEF.md
# Four-knob SPI master shift engine

This block is a single-target SPI master that moves one word per frame. It takes a word from a transmit valid/ready port, shifts it out on MOSI and, over the same frame, collects the word that comes back on MISO. The collected word goes out through a receive valid/ready port. A frame-select output marks the frame. A busy output is high while a frame is in progress.

The serial timing is not chosen with the usual polarity and phase pair. Four separate controls set it instead: the edge type used to sample MISO, the level SCLK rests at, an optional lead-in delay before the first edge, and the edge type on which MOSI advances. The conventional modes are particular settings of these four. The other inputs set the clock divider, the word length from 1 to 32 bits, the bit order and the asserted level of frame select. All settings except the select level and the rest level are latched when a word is accepted. The select level and the rest level act at once, so that software can drive frame select by hand between words.

Top module: `spi_timing_master`

## Requirements
- R1: During and after reset, busy and rx_valid are low, tx_ready is high, SCLK sits at the configured rest level and frame select is at the inverse of the configured select level.
- R2: Each SCLK half-period lasts floor(cfg_div/2) clock cycles. A divider value below 4 acts as 4, so an even value N gives an SCLK period of N cycles.
- R3: While no frame runs, SCLK follows cfg_idle_high (0 low, 1 high). A frame starts from that level and ends back at it.
- R4: The first SCLK edge comes h*(1+e) cycles after frame select asserts, where h is the half-period. e is 0 with the lead-in delay off, 2 with the delay on and launch edge rising, and 1 with the delay on and launch edge falling.
- R5: MISO is sampled only on SCLK edges of the capture type (cfg_cap_fall 0 rising, 1 falling). Exactly one sample is taken per word bit.
- R6: MOSI carries the first bit from the first cycle of the frame. It advances to the next bit on each edge of the launch type (cfg_launch_fall 0 rising, 1 falling) once at least one sample has been taken, until all bits have been sampled.
- R7: cfg_len gives the word length in bits for values 1 to 32. Values 0 and 33 to 63 act as 32.
- R8: cfg_fmt equal to 1 sends and receives least significant bit first. Any other value uses most significant bit first, for both directions.
- R9: The received word is right-justified in rx_data. Bits above the word length are zero.
- R10: Frame select is at cfg_sel_pol during a frame and at its inverse otherwise. A change of cfg_sel_pol between frames reaches the pin at once.
- R11: busy rises in the cycle after a word is accepted. It falls in the same cycle in which rx_valid rises, after SCLK has been back at rest for a half-period.
- R12: A word is accepted only while idle with no unread receive word (tx_ready). rx_valid and rx_data hold until rx_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 8 | SCLK divide ratio in clock cycles |
| cfg_cap_fall | input | 1 | MISO sample edge: 0 rising, 1 falling |
| cfg_idle_high | input | 1 | SCLK rest level |
| cfg_lead_delay | input | 1 | Enables the lead-in delay before the first edge |
| cfg_launch_fall | input | 1 | MOSI advance edge: 0 rising, 1 falling |
| cfg_sel_pol | input | 1 | Asserted level of frame select |
| cfg_len | input | 6 | Word length in bits |
| cfg_fmt | input | 2 | Bit order: 1 selects LSB first |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine can take a transmit word |
| tx_data | input | 32 | Transmit word, right-justified |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receiver takes the word |
| rx_data | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| fsel | output | 1 | Frame select |
| busy | output | 1 | Frame in progress |

## Verification
A wrong sample or launch count appears as a mismatch in rx_data, or in the bits an observing slave collects from MOSI, as soon as the frame's receive word is presented. A miscounted half-period or lead-in shows up on the SCLK pin at the first edge that comes early or late, so it is caught within a single half-period. A faulty end-of-frame sequence shows at once: SCLK is not at rest when busy falls, or rx_valid does not rise together with the fall of busy.

// File: rtl/spi_tm_pkg.sv
package spi_tm_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 6;
    localparam int DIV_W  = 8;
    localparam int HALF_W = DIV_W - 1;
    localparam int LEAD_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_TAIL
    } tm_state_e;

    // Frame settings captured when a word is accepted
    typedef struct packed {
        logic [HALF_W-1:0] half;
        logic              cap_fall;
        logic              idle_high;
        logic              launch_fall;
        logic              lsb_first;
        logic [LEN_W-1:0]  len;
    } tm_cfg_t;

    // Half-period in clock cycles; small ratios clamp to the minimum of 4
    function automatic logic [HALF_W-1:0] half_of(input logic [DIV_W-1:0] div);
        return (div < DIV_W'(4)) ? HALF_W'(2) : div[DIV_W-1:1];
    endfunction

    // Out-of-range lengths act as a full word
    function automatic logic [LEN_W-1:0] len_of(input logic [LEN_W-1:0] len);
        return (len == '0 || len > LEN_W'(WORD_W)) ? LEN_W'(WORD_W) : len;
    endfunction

    // Extra half-periods before the first edge
    function automatic logic [LEAD_W-1:0] lead_of(input logic delay, input logic launch_fall);
        if (!delay)
            return LEAD_W'(0);
        return launch_fall ? LEAD_W'(1) : LEAD_W'(2);
    endfunction

endpackage

// File: rtl/spi_tm_ticker.sv
module spi_tm_ticker #(
    parameter int HW = spi_tm_pkg::HALF_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] half,
    output logic          tick
);

    logic [HW-1:0] cnt;

    assign tick = run && (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/spi_tm_shifter.sv
module spi_tm_shifter #(
    parameter int W  = spi_tm_pkg::WORD_W,
    parameter int LW = spi_tm_pkg::LEN_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [W-1:0]  load_data,
    input  logic          lsb_first,
    input  logic [LW-1:0] len,
    input  logic          launch,
    input  logic          capture,
    input  logic          miso,
    output logic          mosi,
    output logic [W-1:0]  rx_word
);

    logic [W-1:0]  tx_sr;
    logic [W-1:0]  rx_sr;
    logic [LW-1:0] pad;

    assign pad = LW'(W) - len;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else if (load) begin
            tx_sr <= lsb_first ? load_data : (load_data << pad);
            rx_sr <= '0;
        end else begin
            if (capture)
                rx_sr <= lsb_first ? {miso, rx_sr[W-1:1]} : {rx_sr[W-2:0], miso};
            if (launch)
                tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        end
    end

    assign mosi    = lsb_first ? tx_sr[0] : tx_sr[W-1];
    assign rx_word = lsb_first ? (rx_sr >> pad) : rx_sr;

endmodule

// File: rtl/spi_timing_master.sv
module spi_timing_master
    import spi_tm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 cfg_cap_fall,
    input  logic                 cfg_idle_high,
    input  logic                 cfg_lead_delay,
    input  logic                 cfg_launch_fall,
    input  logic                 cfg_sel_pol,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic [1:0]           cfg_fmt,
    input  logic                 tx_valid,
    output logic                 tx_ready,
    input  logic [WORD_W-1:0]    tx_data,
    output logic                 rx_valid,
    input  logic                 rx_ready,
    output logic [WORD_W-1:0]    rx_data,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic                 fsel,
    output logic                 busy
);

    tm_state_e          state;
    tm_cfg_t            cfg_q;
    tm_cfg_t            cfg_new;
    logic               sclk_q;
    logic [LEN_W-1:0]   cap_cnt;
    logic [LEN_W-1:0]   cap_after;
    logic [LEAD_W-1:0]  lead_cnt;
    logic               rx_valid_q;
    logic [WORD_W-1:0]  rx_data_q;

    logic               accept;
    logic               half_tick;
    logic               do_edge;
    logic               edge_fall;
    logic               is_cap;
    logic               is_launch;
    logic               last_cap;
    logic               sh_lsb;
    logic [LEN_W-1:0]   sh_len;
    logic               sh_mosi;
    logic [WORD_W-1:0]  sh_rx;

    always_comb begin
        cfg_new.half        = half_of(cfg_div);
        cfg_new.cap_fall    = cfg_cap_fall;
        cfg_new.idle_high   = cfg_idle_high;
        cfg_new.launch_fall = cfg_launch_fall;
        cfg_new.lsb_first   = (cfg_fmt == 2'd1);
        cfg_new.len         = len_of(cfg_len);
    end

    assign tx_ready = (state == ST_IDLE) && !rx_valid_q;
    assign accept   = tx_ready && tx_valid;

    spi_tm_ticker #(.HW(HALF_W)) ticker_i (
        .clk  (clk),
        .rst  (rst),
        .run  (state != ST_IDLE),
        .half (cfg_q.half),
        .tick (half_tick)
    );

    // SCLK edge bookkeeping: an edge is falling when SCLK is currently high
    assign do_edge   = half_tick && ((state == ST_RUN) ||
                                     (state == ST_LEAD && lead_cnt == '0));
    assign edge_fall = sclk_q;
    assign is_cap    = do_edge && (edge_fall == cfg_q.cap_fall);
    assign cap_after = cap_cnt + LEN_W'(is_cap);
    assign is_launch = do_edge && (edge_fall == cfg_q.launch_fall) &&
                       (cap_after != '0) && (cap_after < cfg_q.len);
    assign last_cap  = is_cap && (cap_after == cfg_q.len);

    assign sh_lsb = (state == ST_IDLE) ? cfg_new.lsb_first : cfg_q.lsb_first;
    assign sh_len = (state == ST_IDLE) ? cfg_new.len : cfg_q.len;

    spi_tm_shifter #(.W(WORD_W), .LW(LEN_W)) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (tx_data),
        .lsb_first (sh_lsb),
        .len       (sh_len),
        .launch    (is_launch),
        .capture   (is_cap),
        .miso      (miso),
        .mosi      (sh_mosi),
        .rx_word   (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            sclk_q     <= 1'b0;
            cap_cnt    <= '0;
            lead_cnt   <= '0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            if (rx_valid_q && rx_ready)
                rx_valid_q <= 1'b0;

            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q    <= cfg_new;
                        sclk_q   <= cfg_idle_high;
                        cap_cnt  <= '0;
                        lead_cnt <= lead_of(cfg_lead_delay, cfg_launch_fall);
                        state    <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (half_tick && lead_cnt != '0)
                        lead_cnt <= lead_cnt - 1'b1;
                end
                ST_TAIL: begin
                    if (half_tick) begin
                        if (sclk_q != cfg_q.idle_high) begin
                            sclk_q <= ~sclk_q;
                        end else begin
                            state      <= ST_IDLE;
                            rx_valid_q <= 1'b1;
                            rx_data_q  <= sh_rx;
                        end
                    end
                end
                default: ;
            endcase

            if (do_edge) begin
                sclk_q  <= ~sclk_q;
                cap_cnt <= cap_after;
                state   <= last_cap ? ST_TAIL : ST_RUN;
            end
        end
    end

    assign busy     = (state != ST_IDLE);
    assign sclk     = busy ? sclk_q : cfg_idle_high;
    assign mosi     = busy ? sh_mosi : 1'b0;
    assign fsel     = busy ? cfg_sel_pol : ~cfg_sel_pol;
    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;

endmodule

// File: rtl/spi_timing_master_chk.sv
module spi_timing_master_chk
    import spi_tm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              sclk,
    input logic              idle_high,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [WORD_W-1:0] rx_data,
    input logic              tick,
    input logic [LEN_W-1:0]  len_q
);

    AST_SCLK_AT_REST: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk == idle_high);                                   // R3

    AST_SCLK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        busy && !tick |=> $stable(sclk));                               // R2

    AST_RX_HELD: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));        // R12

    AST_NO_TAKE_PENDING: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !tx_ready && !busy);                               // R12

    AST_DONE_PRESENTS: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> rx_valid);                                      // R11

    AST_RX_JUSTIFIED: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_data >> len_q) == '0);                         // R9

endmodule

bind spi_timing_master spi_timing_master_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .sclk      (sclk),
    .idle_high (cfg_idle_high),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .rx_data   (rx_data),
    .tick      (half_tick),
    .len_q     (cfg_q.len)
);

// File: tb/spi_timing_master_tb_top.sv
module spi_timing_master_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_div = 8'd4;
    logic        cfg_cap_fall = 1'b0;
    logic        cfg_idle_high = 1'b0;
    logic        cfg_lead_delay = 1'b0;
    logic        cfg_launch_fall = 1'b0;
    logic        cfg_sel_pol = 1'b0;
    logic [5:0]  cfg_len = 6'd8;
    logic [1:0]  cfg_fmt = 2'd0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [31:0] tx_data = '0;
    logic        rx_valid;
    logic        rx_ready = 1'b0;
    logic [31:0] rx_data;
    logic        sclk;
    logic        mosi;
    logic        miso = 1'b0;
    logic        fsel;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int word_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_timing_master dut_i (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cap_fall(cfg_cap_fall),
        .cfg_idle_high(cfg_idle_high), .cfg_lead_delay(cfg_lead_delay),
        .cfg_launch_fall(cfg_launch_fall), .cfg_sel_pol(cfg_sel_pol),
        .cfg_len(cfg_len), .cfg_fmt(cfg_fmt), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .fsel(fsel), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h (word %0d)",
                     req, what, act_v, exp_v, word_idx);
        end
    endtask

    function automatic bit pick(input logic [31:0] d, input int k, input int n, input bit lsbf);
        return lsbf ? d[k] : d[n-1-k];
    endfunction

    task automatic run_word(input int div, input bit capf, input bit idlh, input bit dly,
                            input bit lf, input int len_raw, input int fmt,
                            input logic [31:0] md, input logic [31:0] sd);
        int hp, n, extra, t, caps, first, last, badiv, et;
        bit lsbf, p, pm, s, pol;
        logic [31:0] mask, rec, held;
        hp    = (div < 4) ? 2 : div / 2;
        n     = (len_raw == 0 || len_raw > 32) ? 32 : len_raw;
        extra = dly ? (lf ? 1 : 2) : 0;
        lsbf  = (fmt == 1);
        mask  = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
        pol   = word_idx[0];
        word_idx++;

        @(negedge clk);
        cfg_div = 8'(div); cfg_cap_fall = capf; cfg_idle_high = idlh;
        cfg_lead_delay = dly; cfg_launch_fall = lf; cfg_len = 6'(len_raw);
        cfg_fmt = 2'(fmt); cfg_sel_pol = pol;
        tx_data = md; tx_valid = 1'b1;
        miso = pick(sd, 0, n, lsbf);
        do @(negedge clk); while (!busy);
        tx_valid = 1'b0;

        chk(fsel == pol, "R10", "select asserted", 32'(fsel), 32'(pol));
        chk(sclk == idlh, "R3", "frame starts at rest level", 32'(sclk), 32'(idlh));
        chk(mosi == pick(md, 0, n, lsbf), "R6", "first bit at frame start",
            32'(mosi), 32'(pick(md, 0, n, lsbf)));

        p = sclk; pm = mosi; t = 0; caps = 0; first = -1; last = -1; badiv = 0; rec = '0;
        while (1) begin
            @(negedge clk);
            t++;
            if (!busy) break;
            s = sclk;
            if (s != p) begin
                et = s ? 0 : 1;
                if (first < 0) first = t;
                else if (t - last != hp) badiv++;
                last = t;
                if (et == int'(capf)) begin
                    if (caps < 32) begin
                        if (lsbf) rec[caps] = pm;
                        else      rec = {rec[30:0], pm};
                    end
                    caps++;
                end
                if (et == int'(lf) && caps >= 1 && caps < n)
                    miso = pick(sd, caps, n, lsbf);
            end
            p = s; pm = mosi;
        end

        chk(rx_valid == 1'b1, "R11", "rx_valid with busy fall", 32'(rx_valid), 32'd1);
        chk(rx_data == (sd & mask), "R5", "received word (R8 order)", rx_data, sd & mask);
        chk((rx_data & ~mask) == '0, "R9", "upper bits zero", rx_data & ~mask, 32'd0);
        chk(rec == (md & mask), "R6", "slave-observed MOSI word (R8 order)", rec, md & mask);
        chk(caps == n, "R7", "capture-edge count", 32'(caps), 32'(n));
        chk(first == hp * (1 + extra), "R4", "first edge delay", 32'(first), 32'(hp * (1 + extra)));
        chk(badiv == 0, "R2", "half-period mismatches", 32'(badiv), 32'd0);
        chk(sclk == idlh, "R3", "rest level after frame", 32'(sclk), 32'(idlh));
        chk(fsel == ~pol, "R10", "select released", 32'(fsel), 32'(~pol));
        chk(tx_ready == 1'b0, "R12", "no take while word unread", 32'(tx_ready), 32'd0);

        held = rx_data;
        tx_valid = 1'b1;
        tx_data = ~md;
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R12", "offered word ignored while pending", 32'(busy), 32'd0);
        chk(rx_valid && rx_data == held, "R12", "receive word held", rx_data, held);
        tx_valid = 1'b0;
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(!rx_valid && tx_ready, "R12", "popped and ready",
            32'({rx_valid, tx_ready}), 32'b01);
    endtask

    function automatic int len_pick(input int i);
        case (i)
            0: return 1;
            1: return 5;
            2: return 8;
            3: return 17;
            4: return 32;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] md;
        repeat (3) @(negedge clk);
        chk(sclk == 1'b0 && fsel == 1'b1 && !busy && tx_ready && !rx_valid, "R1",
            "state in reset", 32'({sclk, fsel, busy, tx_ready, rx_valid}), 32'b01010);
        rst = 1'b0;
        @(negedge clk);
        chk(sclk == 1'b0 && fsel == 1'b1 && !busy && tx_ready && !rx_valid, "R1",
            "state after reset", 32'({sclk, fsel, busy, tx_ready, rx_valid}), 32'b01010);

        cfg_sel_pol = 1'b1;
        #1;
        chk(fsel == 1'b0, "R10", "live select level between frames", 32'(fsel), 32'd0);
        cfg_idle_high = 1'b1;
        #1;
        chk(sclk == 1'b1, "R3", "live rest level between frames", 32'(sclk), 32'd1);
        cfg_idle_high = 1'b0;

        for (int m = 0; m < 16; m++)
            for (int li = 0; li < 6; li++)
                for (int o = 0; o < 2; o++)
                    for (int r = 0; r < 2; r++) begin
                        md = 32'h9E37_79B9 * 32'(word_idx + 1) ^ 32'h5A5A_0F0F;
                        run_word(r ? 6 : 4, m[0], m[1], m[2], m[3], len_pick(li), o,
                                 md, {md[15:0], md[31:16]} ^ 32'hC3A5_96E1);
                    end

        // Divider corners (R2) and length/format corners (R7, R8)
        run_word(7,   1'b1, 1'b0, 1'b1, 1'b0, 9,  0, 32'h0000_01A5, 32'h0000_0135);
        run_word(2,   1'b0, 1'b1, 1'b1, 1'b1, 6,  1, 32'h0000_002D, 32'h0000_0016);
        run_word(254, 1'b1, 1'b1, 1'b0, 1'b0, 2,  0, 32'h0000_0002, 32'h0000_0001);
        run_word(0,   1'b0, 1'b0, 1'b0, 1'b1, 40, 1, 32'hDEAD_BEEF, 32'h1234_5678);
        run_word(4,   1'b1, 1'b0, 1'b1, 1'b0, 12, 2, 32'h0000_0A5C, 32'h0000_03C9);
        run_word(6,   1'b0, 1'b1, 1'b0, 1'b1, 12, 3, 32'h0000_0C3A, 32'h0000_0E71);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule